// File: doc/BRIEF.md
# Carrier Level Detector with Amplitude and Time Hysteresis

This block decides, once per clock, whether a usable carrier is present on a receive channel. It takes a digital magnitude estimate of the incoming signal, for example a rectified and low-pass filtered amplitude word. From it the block produces one registered presence flag. The flag depends only on signal energy. It reacts to voice or noise of enough strength just as it reacts to a genuine carrier.

Chatter near the decision level is suppressed in two ways. The first is a pair of thresholds: the flag turns on above the upper level and turns off below the lower level. The second is a pair of qualification counts: the magnitude must stay beyond the relevant threshold for a set number of consecutive samples before the flag changes. A receive-enable input forces the flag low and clears the qualification state. The demodulated bit stream passes through a one-register stage that is gated only by receive-enable and never by the flag.

Top module: `carrier_det_top`

## Requirements
- R1: With receive enabled and the flag low, the flag goes high at the clock edge that samples the Nth consecutive magnitude strictly greater than the upper threshold, where N = max(on_count, 1).
- R2: A magnitude in the dead zone (lower threshold <= magnitude <= upper threshold) changes neither flag state. It breaks a pending assertion run and a pending release run.
- R3: A run of fewer than N samples above the upper threshold, ended by any sample not above it, leaves the flag low. The next qualification starts again from zero.
- R4: With the flag high, the flag goes low at the edge that samples the Mth consecutive magnitude strictly less than the lower threshold, where M = max(off_count, 1). A sample not below the lower threshold restarts that count.
- R5: A clock edge that samples rx_en = 0 drives the flag to 0 and clears both counts, even when a qualification would complete on that same edge. After re-enable, a full N-sample run is needed again.
- R6: Any magnitude pattern whose samples all exceed the upper threshold asserts the flag, whatever their values.
- R7: rx_data_out equals rx_data_in sampled at the previous edge while rx_en was 1, and equals 0 after an edge that sampled rx_en = 0. It is independent of the flag.
- R8: The thresholds and counts are run-time inputs. A count of 0 or 1 means a single sample, and the lower threshold may equal the upper one.
- R9: During and after synchronous reset the flag and rx_data_out are 0 and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive mode enable; 0 forces outputs low |
| amp_in | input | AMP_W | Magnitude estimate, unsigned |
| thr_hi | input | AMP_W | Upper (turn-on) threshold |
| thr_lo | input | AMP_W | Lower (turn-off) threshold, must be <= thr_hi |
| on_count | input | CNT_W | Consecutive samples needed to assert |
| off_count | input | CNT_W | Consecutive samples needed to release |
| rx_data_in | input | 1 | Demodulated bit from the data path |
| rx_data_out | output | 1 | Registered demodulated bit, gated by rx_en |
| carrier_det | output | 1 | Carrier present flag |

## Verification
The two events that can fall on the same edge are a qualification completing, either the Nth sample above the upper threshold or the Mth sample below the lower one, and receive-enable being sampled low. The bench provokes this directly by dropping rx_en on exactly the sample that would complete an assertion run. It also drops rx_en at random points during long random amplitude segments. In each case the enable gating must win: the flag is expected low one edge later, and after re-enable a fresh full-length run is needed before it rises.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAL = 2'd1,
    ST_ON   = 2'd2,
    ST_HOLD = 2'd3
  } cd_state_e;
endpackage

// File: rtl/cd_level_cmp.sv
module cd_level_cmp #(
  parameter int AMP_W = 12
) (
  input  logic [AMP_W-1:0] amp,
  input  logic [AMP_W-1:0] lvl_hi,
  input  logic [AMP_W-1:0] lvl_lo,
  output logic             is_above,
  output logic             is_below
);
  always_comb begin
    is_above = amp > lvl_hi;
    is_below = amp < lvl_lo;
  end
endmodule

// File: rtl/cd_qual_fsm.sv
module cd_qual_fsm
  import cd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             is_above,
  input  logic             is_below,
  input  logic [CNT_W-1:0] need_on,
  input  logic [CNT_W-1:0] need_off,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             flag_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    if (!enable) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_above) begin
            if (need_on <= ONE) begin
              state_d = ST_ON;
              cnt_d   = '0;
            end else begin
              state_d = ST_QUAL;
              cnt_d   = ONE;
            end
          end
        end
        ST_QUAL: begin
          if (!is_above) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else if (cnt_inc >= {1'b0, need_on}) begin
            state_d = ST_ON;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        ST_ON: begin
          if (is_below) begin
            if (need_off <= ONE) begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end else begin
              state_d = ST_HOLD;
              cnt_d   = ONE;
            end
          end
        end
        ST_HOLD: begin
          if (!is_below) begin
            state_d = ST_ON;
            cnt_d   = '0;
          end else if (cnt_inc >= {1'b0, need_off}) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      flag_q  <= (state_d == ST_ON) || (state_d == ST_HOLD);
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/cd_rx_gate.sv
module cd_rx_gate (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bit_in,
  output logic bit_out
);
  logic bit_q;

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= enable & bit_in;
  end

  assign bit_out = bit_q;
endmodule

// File: rtl/carrier_det_top.sv
module carrier_det_top #(
  parameter int AMP_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic [AMP_W-1:0] amp_in,
  input  logic [AMP_W-1:0] thr_hi,
  input  logic [AMP_W-1:0] thr_lo,
  input  logic [CNT_W-1:0] on_count,
  input  logic [CNT_W-1:0] off_count,
  input  logic             rx_data_in,
  output logic             rx_data_out,
  output logic             carrier_det
);
  logic above_w, below_w;

  cd_level_cmp #(.AMP_W(AMP_W)) u_cmp (
    .amp      (amp_in),
    .lvl_hi   (thr_hi),
    .lvl_lo   (thr_lo),
    .is_above (above_w),
    .is_below (below_w)
  );

  cd_qual_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .enable   (rx_en),
    .is_above (above_w),
    .is_below (below_w),
    .need_on  (on_count),
    .need_off (off_count),
    .flag     (carrier_det)
  );

  cd_rx_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .enable  (rx_en),
    .bit_in  (rx_data_in),
    .bit_out (rx_data_out)
  );
endmodule

// File: rtl/cd_checker.sv
module cd_checker #(
  parameter int AMP_W = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic [AMP_W-1:0] amp_in,
  input logic [AMP_W-1:0] thr_hi,
  input logic [AMP_W-1:0] thr_lo,
  input logic [CNT_W-1:0] on_count,
  input logic             rx_data_in,
  input logic             rx_data_out,
  input logic             carrier_det
);
  // R1: a rising flag needs the sample just taken to be above the upper level
  p_rise_above_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(carrier_det) |-> ($past(amp_in) > $past(thr_hi)));

  // R3: with a count of two or more, the previous sample was above as well
  p_no_short_burst_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(carrier_det) && ($past(on_count) >= CNT_W'(2)))
      |-> ($past(amp_in, 2) > $past(thr_hi, 2)));

  // R4: a fall while enabled needs the sample just taken to be below the lower level
  p_fall_below_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(carrier_det) && $past(rx_en)) |-> ($past(amp_in) < $past(thr_lo)));

  // R5: disabled receive forces the flag low on the next edge
  p_off_when_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !carrier_det);

  // R7: data path follows its input whenever enabled
  p_data_follows_r7: assert property (@(posedge clk) disable iff (rst)
    rx_en |=> (rx_data_out == $past(rx_data_in)));

  // R7: data path low after a disabled edge
  p_data_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_data_out);
endmodule

bind carrier_det_top cd_checker #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_en       (rx_en),
  .amp_in      (amp_in),
  .thr_hi      (thr_hi),
  .thr_lo      (thr_lo),
  .on_count    (on_count),
  .rx_data_in  (rx_data_in),
  .rx_data_out (rx_data_out),
  .carrier_det (carrier_det)
);

// File: tb/sim_carrier_det_top.sv
`timescale 1ns/1ps
module sim_carrier_det_top;
  localparam int AMP_W = 12;
  localparam int CNT_W = 16;
  localparam int AMP_MAX = (1 << AMP_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rx_en = 1'b0;
  logic [AMP_W-1:0] amp_in = '0;
  logic [AMP_W-1:0] thr_hi = AMP_W'(100);
  logic [AMP_W-1:0] thr_lo = AMP_W'(60);
  logic [CNT_W-1:0] on_count = CNT_W'(5);
  logic [CNT_W-1:0] off_count = CNT_W'(4);
  logic             rx_data_in = 1'b0;
  logic             rx_data_out;
  logic             carrier_det;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench reference state
  bit m_det = 0;
  bit m_data = 0;
  int run_up = 0;
  int run_dn = 0;

  always #4 clk = ~clk;

  carrier_det_top #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .amp_in(amp_in),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .on_count(on_count),
    .off_count(off_count), .rx_data_in(rx_data_in),
    .rx_data_out(rx_data_out), .carrier_det(carrier_det)
  );

  function automatic int need(input logic [CNT_W-1:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // advance one edge and update the reference from the sampled inputs
  task automatic tick(input string req);
    if (rst || !rx_en) begin
      m_det = 0; run_up = 0; run_dn = 0;
      m_data = 0;
    end else begin
      run_up = (amp_in > thr_hi) ? run_up + 1 : 0;
      run_dn = (amp_in < thr_lo) ? run_dn + 1 : 0;
      if (!m_det && run_up >= need(on_count)) m_det = 1;
      else if (m_det && run_dn >= need(off_count)) m_det = 0;
      m_data = rx_data_in;
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, int'(carrier_det), int'(m_det));
    chk({req, "/R7"}, int'(rx_data_out), int'(m_data));
  endtask

  task automatic hold(input int a, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      amp_in = AMP_W'(a);
      tick(req);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    tick("R9"); tick("R9");
    chk("R9 reset flag", int'(carrier_det), 0);
    chk("R9 reset data", int'(rx_data_out), 0);
    rst = 1'b0;
    rx_en = 1'b1;

    // R3: short bursts and restart
    hold(150, 4, "R3");
    hold(80, 1, "R3");
    hold(150, 4, "R3");
    chk("R3 burst shorter than count", int'(carrier_det), 0);
    // R1: the fifth consecutive sample asserts
    hold(150, 1, "R1");
    chk("R1 assert on Nth sample", int'(carrier_det), 1);
    // R2: dead zone holds the flag high
    hold(80, 10, "R2");
    chk("R2 dead zone keeps high", int'(carrier_det), 1);
    // R4: release delay and restart
    hold(30, 3, "R4");
    hold(80, 1, "R4");
    hold(30, 3, "R4");
    chk("R4 release restarted", int'(carrier_det), 1);
    hold(30, 1, "R4");
    chk("R4 release on Mth sample", int'(carrier_det), 0);
    hold(80, 10, "R2");
    chk("R2 dead zone keeps low", int'(carrier_det), 0);
    // R5: disable forces low and clears the count
    hold(150, 5, "R5");
    rx_en = 1'b0;
    hold(150, 1, "R5");
    chk("R5 disable forces low", int'(carrier_det), 0);
    rx_en = 1'b1;
    hold(150, 4, "R5");
    chk("R5 count cleared", int'(carrier_det), 0);
    hold(150, 1, "R5");
    chk("R5 requalified", int'(carrier_det), 1);
    // R5: disable on the same edge a qualification completes
    hold(30, 4, "R5");
    hold(150, 4, "R5");
    rx_en = 1'b0;
    hold(150, 1, "R5");
    chk("R5 collision disable wins", int'(carrier_det), 0);
    // R7: data passes with flag low, gated when disabled
    rx_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      rx_data_in = i[0];
      hold(10, 1, "R7");
      chk("R7 data with flag low", int'(rx_data_out), i & 1);
    end
    rx_data_in = 1'b1;
    rx_en = 1'b0;
    hold(10, 1, "R7");
    chk("R7 data gated", int'(rx_data_out), 0);
    rx_en = 1'b1;
    // R8: single-sample counts and equal thresholds
    on_count = '0; off_count = CNT_W'(1);
    hold(150, 1, "R8");
    chk("R8 zero count asserts at once", int'(carrier_det), 1);
    hold(30, 1, "R8");
    chk("R8 one-sample release", int'(carrier_det), 0);
    thr_lo = AMP_W'(100);
    hold(100, 3, "R8");
    chk("R8 equal thresholds, at level", int'(carrier_det), 0);
    hold(101, 1, "R8");
    hold(100, 3, "R8");
    chk("R8 equal thresholds, held", int'(carrier_det), 1);
    // R6: varying strong amplitudes assert
    thr_hi = AMP_W'(100); thr_lo = AMP_W'(60);
    on_count = CNT_W'(7); off_count = CNT_W'(3);
    hold(0, 3, "R6");
    for (int i = 0; i < 7; i++) hold(101 + int'($urandom % (AMP_MAX - 101)), 1, "R6");
    chk("R6 energy only assert", int'(carrier_det), 1);

    // random segments
    for (int s = 0; s < 1200; s++) begin
      int cls, len, lo, hi, a;
      if (s % 60 == 59) begin
        hi = 20 + int'($urandom % 3900);
        lo = hi - int'($urandom % (hi + 1));
        thr_hi = AMP_W'(hi); thr_lo = AMP_W'(lo);
        on_count = CNT_W'($urandom % 13);
        off_count = CNT_W'($urandom % 13);
      end
      hi = int'(thr_hi); lo = int'(thr_lo);
      cls = int'($urandom % 3);
      if (cls == 2 && lo == 0) cls = 1;
      len = 1 + int'($urandom % (2 * need(on_count) + 3));
      for (int k = 0; k < len; k++) begin
        case (cls)
          0: a = hi + 1 + int'($urandom % (AMP_MAX - hi));
          1: a = lo + int'($urandom % (hi - lo + 1));
          default: a = int'($urandom % lo);
        endcase
        rx_data_in = $urandom % 2;
        rx_en = ($urandom % 40) != 0;
        hold(a, 1, "R1/R4 random");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule